// File: doc/BRIEF.md
# Cartridge ROM Emulator with Staged Payload

This block stands in for the ROM of a game cartridge. It answers read strobes on a 16-bit cartridge address bus and returns a byte chosen by the address and by a boot phase that the block tracks itself. While the console's start-up code is still checking the cartridge header, the window 0x0100–0x0150 returns a consistent header, including a valid checksum. Once that check has been seen a set number of times, the same window returns a short payload program instead.

Every other ROM address returns the no-operation opcode. The exception is the last three bytes of the ROM area, which hold an absolute jump to 0x0100. A processor that lands anywhere in the ROM area therefore slides through no-operations and ends up in the payload. An external input can force the payload phase at any time.

Top module: `cart_rom_emu`

## Requirements
- R1: After rst_ni is released, data_oe_o is 0 and the block is in the header phase. In that phase a read of 0x0100 returns 0x00.
- R2: A read is any cycle with rd_i high. If the address is below 0x8000, data_oe_o is 1 and data_o holds the byte on the cycle after the read. In every other case data_oe_o is 0 and data_o is 0x00 on the following cycle.
- R3: An address below 0x8000 that is outside 0x0100–0x0150 and outside 0x7FFD–0x7FFF returns 0x00 in both phases.
- R4: Addresses 0x7FFD, 0x7FFE and 0x7FFF return 0xC3, 0x00 and 0x01, in both phases.
- R5: In the header phase, 0x0100–0x0103 return 0x00, 0xC3, 0x50, 0x01. Every other address a in 0x0104–0x0150, except 0x014D, returns the low byte of (a−0x0100)·7+0x31.
- R6: In the header phase, 0x014D returns 0xE7 minus the 8-bit sum of the bytes at 0x0134–0x014C.
- R7: A header check counts when rd_i rises while the address is 0x014D. The check that brings the count to pass_limit_i still returns header data. Reads from the next one onward are in the payload phase. A pass_limit_i of 0 acts as 1, and a strobe held high counts only once.
- R8: In the payload phase, 0x0100–0x0107 return 0x21, 0x00, 0x00, 0x2A, 0x16, 0xA1, 0x5F, 0x12, and 0x0108–0x0150 return 0x00.
- R9: If force_payload_i is high at a clock edge, reads from the next cycle onward are in the payload phase.
- R10: The payload phase holds until rst_ni is asserted, and reset returns the block to the header phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Cartridge address bus |
| rd_i | input | 1 | Read strobe, active high |
| pass_limit_i | input | 4 | Number of header checks before the payload phase |
| force_payload_i | input | 1 | Forces the payload phase |
| data_o | output | 8 | Read data, 0x00 when not enabled |
| data_oe_o | output | 1 | Output enable for the data bus driver |

## Verification
Every read result, including the output-enable, appears exactly one cycle after the cycle in which the strobe and address were presented. A phase change from the header-check count or from the force input affects only the reads presented on later cycles. The driver applies one stimulus per cycle on the falling edge. At that moment it also queues the expected result, computed with the model phase as it stood before that cycle's update. The monitor pops one entry per cycle just after each rising edge, so every comparison lands on the cycle where the registered output is due.

// File: rtl/cart_rom_pkg.sv
package cart_rom_pkg;
  localparam logic [7:0]  NOP_OP   = 8'h00;
  localparam logic [7:0]  JP_OP    = 8'hC3;
  localparam logic [15:0] HDR_LO   = 16'h0100;
  localparam logic [15:0] HDR_HI   = 16'h0150;
  localparam logic [15:0] CHK_ADDR = 16'h014D;
  localparam logic [15:0] SUM_LO   = 16'h0134;
  localparam logic [15:0] SUM_HI   = 16'h014C;
  localparam logic [15:0] JP_ADDR  = 16'h7FFD;
  localparam logic [15:0] ROM_END  = 16'h8000;
  localparam logic [15:0] PAY_TGT  = 16'h0100;
  localparam int          PAY_DEPTH = 8;

  typedef enum logic {PH_HDR = 1'b0, PH_PAY = 1'b1} phase_e;

  function automatic logic [7:0] hdr_fill(input logic [15:0] off);
    logic [15:0] t;
    t = off * 16'd7 + 16'h0031;
    return t[7:0];
  endfunction

  function automatic logic [7:0] hdr_sum();
    logic [7:0] s;
    s = 8'h00;
    for (int a = int'(SUM_LO); a <= int'(SUM_HI); a++)
      s = s + hdr_fill(16'(a) - HDR_LO);
    return 8'hE7 - s;
  endfunction

  function automatic logic [7:0] pay_byte(input logic [15:0] off);
    case (off)
      16'd0: return 8'h21;
      16'd1: return 8'h00;
      16'd2: return 8'h00;
      16'd3: return 8'h2A;
      16'd4: return 8'h16;
      16'd5: return 8'hA1;
      16'd6: return 8'h5F;
      16'd7: return 8'h12;
      default: return NOP_OP;
    endcase
  endfunction
endpackage

// File: rtl/cart_phase_ctrl.sv
module cart_phase_ctrl
  import cart_rom_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic [CNT_W-1:0]  limit_i,
  input  logic              force_i,
  output phase_e            phase_o
);
  localparam logic [ADDR_W-1:0] CHK_L = ADDR_W'(CHK_ADDR);

  logic             rd_q;
  logic [CNT_W-1:0] cnt_q;
  phase_e           phase_q;
  logic             chk_hit;
  logic [CNT_W:0]   cnt_inc;
  logic             trip;

  assign chk_hit = rd_i && !rd_q && (addr_i == CHK_L);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign trip    = chk_hit && (cnt_inc >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      cnt_q   <= '0;
      phase_q <= PH_HDR;
    end else begin
      rd_q <= rd_i;
      if (chk_hit && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      if (trip || force_i) phase_q <= PH_PAY;
    end
  end

  assign phase_o = phase_q;

  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_PAY |=> phase_q == PH_PAY);
  assert_force_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> phase_q == PH_PAY);
  // no switch unless a check read or the force input is present
  assert_no_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HDR && !force_i && !(rd_i && addr_i == CHK_L)) |=> phase_q == PH_HDR);
endmodule

// File: rtl/cart_rom_map.sv
module cart_rom_map
  import cart_rom_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  phase_e            phase_i,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [7:0] CHK_VAL = hdr_sum();

  logic [15:0] a16;
  logic [15:0] off;
  logic [7:0]  hdr_b;
  logic [7:0]  byte_b;

  assign a16 = 16'(addr_i);
  assign off = a16 - HDR_LO;

  always_comb begin
    case (off)
      16'd0:   hdr_b = NOP_OP;
      16'd1:   hdr_b = JP_OP;
      16'd2:   hdr_b = 8'h50;
      16'd3:   hdr_b = 8'h01;
      default: hdr_b = (a16 == CHK_ADDR) ? CHK_VAL : hdr_fill(off);
    endcase
  end

  always_comb begin
    if (a16 >= HDR_LO && a16 <= HDR_HI)
      byte_b = (phase_i == PH_PAY) ? pay_byte(off) : hdr_b;
    else if (a16 == JP_ADDR)
      byte_b = JP_OP;
    else if (a16 == JP_ADDR + 16'd1)
      byte_b = PAY_TGT[7:0];
    else if (a16 == JP_ADDR + 16'd2)
      byte_b = PAY_TGT[15:8];
    else
      byte_b = NOP_OP;
  end

  assign data_o = DATA_W'(byte_b);
endmodule

// File: rtl/cart_rom_emu.sv
module cart_rom_emu
  import cart_rom_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic [CNT_W-1:0]  pass_limit_i,
  input  logic              force_payload_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam logic [ADDR_W-1:0] ROM_END_L = ADDR_W'(ROM_END);
  localparam logic [ADDR_W-1:0] JP_L      = ADDR_W'(JP_ADDR);

  phase_e            phase;
  logic [DATA_W-1:0] map_d;
  logic              in_rom;
  logic [DATA_W-1:0] data_q;
  logic              oe_q;

  cart_phase_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .rd_i    (rd_i),
    .limit_i (pass_limit_i),
    .force_i (force_payload_i),
    .phase_o (phase)
  );

  cart_rom_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_map (
    .addr_i  (addr_i),
    .phase_i (phase),
    .data_o  (map_d)
  );

  assign in_rom = addr_i < ROM_END_L;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      data_q <= '0;
    end else begin
      oe_q   <= rd_i && in_rom;
      data_q <= (rd_i && in_rom) ? map_d : '0;
    end
  end

  assign data_o    = data_q;
  assign data_oe_o = oe_q;

  assert_drive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && in_rom) |=> data_oe_o);
  assert_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && in_rom) |=> (!data_oe_o && data_o == '0));
  assert_jump_op_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == JP_L) |=> data_o == DATA_W'(JP_OP));
  assert_sled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(16'h4000)) |=> data_o == '0);
endmodule

// File: tb/cart_rom_emu_tb.sv
module cart_rom_emu_tb;
  typedef struct {
    logic       oe;
    logic [7:0] d;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0;
  logic [3:0]  limit = 4'd3;
  logic        frc = 1'b0;
  logic [7:0]  data_o;
  logic        data_oe_o;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  // bench model state
  bit       m_pay = 0;
  int       m_cnt = 0;
  bit       m_rdq = 0;

  always #2 clk = ~clk;

  cart_rom_emu u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .addr_i          (addr),
    .rd_i            (rd),
    .pass_limit_i    (limit),
    .force_payload_i (frc),
    .data_o          (data_o),
    .data_oe_o       (data_oe_o)
  );

  function automatic logic [7:0] fill(input int a);
    return 8'((a - 16'h0100) * 7 + 16'h31);
  endfunction

  function automatic logic [7:0] bexp(input logic [15:0] a, input bit pay);
    logic [7:0] s;
    logic [7:0] pt [8] = '{8'h21, 8'h00, 8'h00, 8'h2A, 8'h16, 8'hA1, 8'h5F, 8'h12};
    if (a >= 16'h0100 && a <= 16'h0150) begin
      if (pay) return (a < 16'h0108) ? pt[a - 16'h0100] : 8'h00;
      case (a)
        16'h0100: return 8'h00;
        16'h0101: return 8'hC3;
        16'h0102: return 8'h50;
        16'h0103: return 8'h01;
        16'h014D: begin
          s = 0;
          for (int i = 16'h0134; i <= 16'h014C; i++) s = s + fill(i);
          return 8'hE7 - s;
        end
        default: return fill(int'(a));
      endcase
    end
    if (a == 16'h7FFD) return 8'hC3;
    if (a == 16'h7FFE) return 8'h00;
    if (a == 16'h7FFF) return 8'h01;
    return 8'h00;
  endfunction

  task automatic step(input logic r, input logic [15:0] a, input logic f, input string tag);
    exp_t e;
    @(negedge clk);
    rd = r; addr = a; frc = f;
    e.oe  = r && (a < 16'h8000);
    e.d   = e.oe ? bexp(a, m_pay) : 8'h00;
    e.tag = tag;
    q.push_back(e);
    if (r && !m_rdq && a == 16'h014D) begin
      if (m_cnt + 1 >= int'(limit)) m_pay = 1;
      if (m_cnt < 15) m_cnt++;
    end
    if (f) m_pay = 1;
    m_rdq = r;
  endtask

  task automatic rd1(input logic [15:0] a, input string tag);
    step(1'b1, a, 1'b0, tag);
    step(1'b0, 16'h0000, 1'b0, tag);
  endtask

  task automatic do_reset(input logic [3:0] lim);
    @(negedge clk);
    rst_n = 1'b0; rd = 1'b0; frc = 1'b0; limit = lim;
    m_pay = 0; m_cnt = 0; m_rdq = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (data_oe_o !== e.oe || data_o !== e.d) begin
        n_fail++;
        $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h",
                 e.tag, data_oe_o, data_o, e.oe, e.d);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++; // R1 reset state
    if (data_oe_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: oe=%0b expected 0", data_oe_o);
    end
    rd1(16'h0100, "R1");
    // R3 sled
    rd1(16'h0000, "R3"); rd1(16'h2345, "R3"); rd1(16'h4000, "R3"); rd1(16'h7FFC, "R3");
    // R4 jump at top
    rd1(16'h7FFD, "R4"); rd1(16'h7FFE, "R4"); rd1(16'h7FFF, "R4");
    // R2 outside ROM and idle
    rd1(16'h8000, "R2"); rd1(16'hA100, "R2"); rd1(16'hFFFF, "R2");
    step(1'b0, 16'h1234, 1'b0, "R2");
    // R5 R6 header, two full passes with limit 3
    for (int p = 0; p < 2; p++)
      for (int a = 16'h0100; a <= 16'h0150; a++) rd1(16'(a), (a == 16'h014D) ? "R6" : "R5");
    // R7 held strobe counts once: this is the third check, it trips
    step(1'b1, 16'h014D, 1'b0, "R7");
    step(1'b1, 16'h014D, 1'b0, "R7");
    step(1'b0, 16'h0000, 1'b0, "R7");
    // R8 payload window
    for (int a = 16'h0100; a <= 16'h0150; a++) rd1(16'(a), "R8");
    rd1(16'h0050, "R3"); rd1(16'h7FFD, "R4");
    // R10 reset returns header, held strobe with limit 2 does not trip
    do_reset(4'd2);
    rd1(16'h0100, "R10");
    step(1'b1, 16'h014D, 1'b0, "R7");
    step(1'b1, 16'h014D, 1'b0, "R7");
    step(1'b1, 16'h014D, 1'b0, "R7");
    step(1'b0, 16'h0000, 1'b0, "R7");
    rd1(16'h0100, "R7");
    // R9 force
    step(1'b0, 16'h0000, 1'b1, "R9");
    rd1(16'h0100, "R9"); rd1(16'h0105, "R9");
    // R10 sticky after force drops
    for (int i = 0; i < 5; i++) step(1'b0, 16'h0000, 1'b0, "R10");
    rd1(16'h0103, "R10");
    // R7 limit 0 acts as 1
    do_reset(4'd0);
    rd1(16'h0101, "R7");
    rd1(16'h014D, "R7");
    rd1(16'h0101, "R7");
    rd1(16'h0106, "R8");
    step(1'b0, 16'h0000, 1'b0, "R2");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule